// File: doc/BRIEF.md
# Audio Codec Power-Up Sequencer over I2C

This block brings a stereo audio codec out of power-down with no processor involved. After reset, or when a start pulse arrives while it is idle, it walks a fixed list of eleven register writes and four timed pauses. Each write goes out as one I2C write transaction to device address 0x1A. The block checks every acknowledge slot. At the end it raises done, or it raises error as soon as the codec refuses a byte.

A codec register value is 9 bits wide. The top bit of the value travels in the low bit of the byte that carries the register number. The order of the writes matters. The codec is first reset to its defaults. The output stage is powered up only after the digital core is running, and a pause separates that power-up from the final DAC enable. Both lines are open-drain: the block only ever pulls a line low or lets it float, and the board's pull-ups supply the high level.

Top module: `codec_init_top`

## Requirements
- R1: Every transaction begins with a START condition followed by the address byte 0x34, which is the 7-bit address 0x1A with R/W = 0. Each transaction then carries exactly two more bytes and ends with a STOP.
- R2: The first data byte of each write is {register number[6:0], value[8]}.
- R3: The writes go out in this order, as (register, 9-bit value): (15,0x000) (6,0x070) (2,0x179) (3,0x179) (4,0x000) (5,0x000) (7,0x001) (8,0x000) (9,0x001) (6,0x020) (4,0x016). The second data byte of each write is value[7:0].
- R4: At least PAUSE_CYCLES clock cycles (1 ms by default) pass between the STOP of one write and the START of the next at four points only: after the register 15 write, after the register 8 write, after the register 9 write, and after the second register 6 write. Between all other writes the gap is shorter than PAUSE_CYCLES.
- R5: SCL runs at clk/(4*QUARTER_CYCLES), which is 100 kHz for a 100 MHz clock at the default of 250. Each SCL high phase lasts 2*QUARTER_CYCLES cycles, and consecutive SCL edges are at least QUARTER_CYCLES cycles apart.
- R6: SDA changes only while SCL is low, except for the START and STOP conditions. SDA and SCL never change in the same clock cycle. Each write produces exactly one START and one STOP.
- R7: SDA is sampled while SCL is high in every acknowledge slot. A high level there (NACK) ends the transaction with a STOP, abandons the rest of the list and sets error. No further transaction follows. error stays high until the next start or reset.
- R8: done rises only after the STOP of the last write and stays high until the next start or reset. done and error are never high together.
- R9: A start pulse that arrives while the sequence is running has no effect. The sequence neither restarts nor repeats any write.
- R10: The sequence starts by itself after reset, with done and error low. A start pulse while idle clears done and error and runs the whole list again from the first write.
- R11: sclOe and sdaOe are 1 only to pull a line low. Both are 0 while the block is idle, done or in error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the sequence starts when it is released |
| start | input | 1 | Single-cycle request to rerun the sequence; ignored while busy |
| sdaIn | input | 1 | Sampled level of the SDA line |
| sclOe | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | Sequence finished with every byte acknowledged |
| error | output | 1 | Sequence aborted on a NACK |

## Verification
Some rules hold on every cycle, and the bound checker watches those. It checks that SCL edges are never closer than a quarter bit period and that SDA never moves in the same cycle as SCL. It also checks that done and error are exclusive and each holds until a start, and that both lines are released whenever the block reports a result. The bench's scenarios cover what only shows across a whole run. A codec model decodes every byte, so the bench can confirm the exact write order, the 9-bit value packing, where the pauses fall and how long they last, the abort on a NACK in the address byte and in a data byte, and that a start while busy is ignored.

// File: rtl/codec_init_pkg.sv
package codec_init_pkg;

  localparam logic [6:0] DEV_ADDR = 7'h1A;
  localparam int SEQ_LEN = 15;
  localparam int IDX_W = $clog2(SEQ_LEN);

  // Control to bit engine: one transaction request
  typedef struct packed {
    logic       go;
    logic [7:0] regByte;
    logic [7:0] valByte;
  } i2cCmd_t;

  // Bit engine to control: transaction finished
  typedef struct packed {
    logic fin;
    logic nack;
  } i2cRsp_t;

  typedef struct packed {
    logic       isPause;
    logic [6:0] regNum;
    logic [8:0] value;
  } seqStep_t;

  // Power-up list: register reset first, output stage last-but-one,
  // DAC enable last with a pause before it
  function automatic seqStep_t seqStep(input logic [IDX_W-1:0] idx);
    seqStep_t s;
    s = '0;
    case (idx)
      4'd0:  begin s.regNum = 7'd15; s.value = 9'h000; end
      4'd1:  s.isPause = 1'b1;
      4'd2:  begin s.regNum = 7'd6;  s.value = 9'h070; end
      4'd3:  begin s.regNum = 7'd2;  s.value = 9'h179; end
      4'd4:  begin s.regNum = 7'd3;  s.value = 9'h179; end
      4'd5:  begin s.regNum = 7'd4;  s.value = 9'h000; end
      4'd6:  begin s.regNum = 7'd5;  s.value = 9'h000; end
      4'd7:  begin s.regNum = 7'd7;  s.value = 9'h001; end
      4'd8:  begin s.regNum = 7'd8;  s.value = 9'h000; end
      4'd9:  s.isPause = 1'b1;
      4'd10: begin s.regNum = 7'd9;  s.value = 9'h001; end
      4'd11: s.isPause = 1'b1;
      4'd12: begin s.regNum = 7'd6;  s.value = 9'h020; end
      4'd13: s.isPause = 1'b1;
      4'd14: begin s.regNum = 7'd4;  s.value = 9'h016; end
      default: s.isPause = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ci_sequencer.sv
module ci_sequencer
  import codec_init_pkg::*;
#(
  parameter int PAUSE_CYCLES = 100000
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  i2cRsp_t rsp,
  output i2cCmd_t cmd,
  output logic    done,
  output logic    error
);

  localparam int PW = $clog2(PAUSE_CYCLES) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_XFER, S_PAUSE} seqState_t;

  seqState_t        state;
  logic [IDX_W-1:0] idx;
  logic [PW-1:0]    pauseCnt;
  seqStep_t         step;
  logic             stepDone;
  logic             lastStep;

  assign step     = seqStep(idx);
  assign lastStep = (idx == IDX_W'(SEQ_LEN - 1));
  assign stepDone = (state == S_XFER && rsp.fin && !rsp.nack) ||
                    (state == S_PAUSE && pauseCnt == PW'(PAUSE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_ISSUE;
      idx      <= '0;
      pauseCnt <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
      cmd      <= '0;
    end else begin
      cmd.go <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          idx   <= '0;
          done  <= 1'b0;
          error <= 1'b0;
          state <= S_ISSUE;
        end
        S_ISSUE: begin
          if (step.isPause) begin
            pauseCnt <= '0;
            state    <= S_PAUSE;
          end else begin
            cmd.go      <= 1'b1;
            cmd.regByte <= {step.regNum, step.value[8]};
            cmd.valByte <= step.value[7:0];
            state       <= S_XFER;
          end
        end
        S_XFER: if (rsp.fin && rsp.nack) begin
          error <= 1'b1;
          state <= S_IDLE;
        end
        S_PAUSE: pauseCnt <= pauseCnt + 1'b1;
        default: state <= S_IDLE;
      endcase
      if (stepDone) begin
        if (lastStep) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end else begin
          idx   <= idx + 1'b1;
          state <= S_ISSUE;
        end
      end
    end
  end

endmodule

// File: rtl/ci_i2c_phy.sv
module ci_i2c_phy
  import codec_init_pkg::*;
#(
  parameter int QUARTER_CYCLES = 250
) (
  input  logic    clk,
  input  logic    rst,
  input  i2cCmd_t cmd,
  output i2cRsp_t rsp,
  input  logic    sdaIn,
  output logic    sclOe,
  output logic    sdaOe
);

  localparam int QW = $clog2(QUARTER_CYCLES) + 1;
  localparam int FRAME_W = 24;

  typedef enum logic [1:0] {P_IDLE, P_START, P_BIT, P_STOP} phyState_t;

  phyState_t        state;
  logic [1:0]       qPh;
  logic [QW-1:0]    divCnt;
  logic [FRAME_W-1:0] frame;
  logic [3:0]       bitInByte;
  logic [1:0]       byteIdx;
  logic             nackSeen;
  logic [1:0]       sdaSync;
  logic             tick;
  logic             ackSlot;

  assign tick    = (state != P_IDLE) && (divCnt == QW'(QUARTER_CYCLES - 1));
  assign ackSlot = (bitInByte == 4'd8);

  // Each phase holds for one quarter bit; SCL and SDA move on different quarters
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= P_IDLE;
      qPh       <= '0;
      divCnt    <= '0;
      frame     <= '0;
      bitInByte <= '0;
      byteIdx   <= '0;
      nackSeen  <= 1'b0;
      sdaSync   <= 2'b11;
      sclOe     <= 1'b0;
      sdaOe     <= 1'b0;
      rsp       <= '0;
    end else begin
      rsp.fin <= 1'b0;
      sdaSync <= {sdaSync[0], sdaIn};
      if (state == P_IDLE) begin
        divCnt <= '0;
        qPh    <= '0;
        if (cmd.go) begin
          frame     <= {DEV_ADDR, 1'b0, cmd.regByte, cmd.valByte};
          bitInByte <= '0;
          byteIdx   <= '0;
          nackSeen  <= 1'b0;
          state     <= P_START;
        end
      end else if (tick) begin
        divCnt <= '0;
        qPh    <= qPh + 2'd1;
        case (state)
          P_START: case (qPh)
            2'd0: sdaOe <= 1'b1;
            2'd1: sclOe <= 1'b1;
            2'd3: state <= P_BIT;
            default: ;
          endcase
          P_BIT: case (qPh)
            2'd0: sdaOe <= ackSlot ? 1'b0 : ~frame[FRAME_W-1];
            2'd1: sclOe <= 1'b0;
            2'd2: if (ackSlot) nackSeen <= sdaSync[1];
            default: begin
              sclOe <= 1'b1;
              if (ackSlot) begin
                if (nackSeen || byteIdx == 2'd2) begin
                  state <= P_STOP;
                end else begin
                  bitInByte <= '0;
                  byteIdx   <= byteIdx + 2'd1;
                end
              end else begin
                frame     <= frame << 1;
                bitInByte <= bitInByte + 4'd1;
              end
            end
          endcase
          P_STOP: case (qPh)
            2'd0: sdaOe <= 1'b1;
            2'd1: sclOe <= 1'b0;
            2'd2: sdaOe <= 1'b0;
            default: begin
              state    <= P_IDLE;
              rsp.fin  <= 1'b1;
              rsp.nack <= nackSeen;
            end
          endcase
          default: state <= P_IDLE;
        endcase
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/codec_init_top.sv
module codec_init_top
  import codec_init_pkg::*;
#(
  parameter int QUARTER_CYCLES = 250,
  parameter int PAUSE_CYCLES   = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic sdaIn,
  output logic sclOe,
  output logic sdaOe,
  output logic done,
  output logic error
);

  i2cCmd_t cmd;
  i2cRsp_t rsp;

  ci_sequencer #(.PAUSE_CYCLES(PAUSE_CYCLES)) i_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .rsp   (rsp),
    .cmd   (cmd),
    .done  (done),
    .error (error)
  );

  ci_i2c_phy #(.QUARTER_CYCLES(QUARTER_CYCLES)) i_phy (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd),
    .rsp   (rsp),
    .sdaIn (sdaIn),
    .sclOe (sclOe),
    .sdaOe (sdaOe)
  );

endmodule

// File: rtl/codec_init_chk.sv
module codec_init_chk #(
  parameter int QUARTER_CYCLES = 250
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic sclOe,
  input logic sdaOe,
  input logic done,
  input logic error
);

  localparam int GW = $clog2(QUARTER_CYCLES) + 2;

  logic          sclPrev;
  logic [GW-1:0] sclGap;
  logic          sclEdge;

  assign sclEdge = (sclOe != sclPrev);

  // Cycles since the previous SCL edge, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      sclPrev <= 1'b0;
      sclGap  <= '0;
    end else begin
      sclPrev <= sclOe;
      if (sclEdge) sclGap <= GW'(1);
      else if (sclGap != {GW{1'b1}}) sclGap <= sclGap + 1'b1;
    end
  end

  a_r5_scl_edge_spacing: assert property (@(posedge clk) disable iff (rst)
    sclEdge |-> sclGap >= GW'(QUARTER_CYCLES));

  a_r6_lines_never_move_together: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdaOe) |-> $stable(sclOe));

  a_r8_done_error_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && error));

  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);

  a_r7_error_holds: assert property (@(posedge clk) disable iff (rst)
    error && !start |=> error);

  a_r11_released_when_finished: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> (!sclOe && !sdaOe));

endmodule

bind codec_init_top codec_init_chk #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .sclOe (sclOe),
  .sdaOe (sdaOe),
  .done  (done),
  .error (error)
);

// File: tb/test_codec_init_top.sv
module test_codec_init_top;

  localparam int Q = 4;
  localparam int W = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sclOe, sdaOe, done, error;
  logic sdaIn;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  // Codec model state
  logic ackDrive = 1'b0;
  logic sclPrev = 1'b1, sdaPrev = 1'b1;
  logic inFrame = 1'b0, ackPhase = 1'b0;
  logic [7:0] shiftIn = '0;
  int bitCnt = 0, byteCnt = 0;
  int transCnt = 0, startCnt = 0, stopCnt = 0;
  int highLen = 0, lastHigh = 0;
  int nackTrans = -1, nackByte = 0;
  logic [7:0] byteLog [0:63][0:2];
  int startAt [0:63];
  int stopAt  [0:63];

  logic sclLine, sdaLine;
  assign sclLine = ~sclOe;
  assign sdaLine = ~(sdaOe | ackDrive);
  assign sdaIn   = sdaLine;

  codec_init_top #(.QUARTER_CYCLES(Q), .PAUSE_CYCLES(W)) i_codec_init_top (
    .clk(clk), .rst(rst), .start(start), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .done(done), .error(error)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Codec model, sampled away from the active edge
  always @(negedge clk) begin
    sclPrev <= sclLine;
    sdaPrev <= sdaLine;
    highLen <= sclLine ? highLen + 1 : 0;
    if (sclPrev && sclLine && sdaPrev && !sdaLine) begin
      startCnt <= startCnt + 1;
      startAt[transCnt[5:0]] <= cyc;
      inFrame <= 1'b1; bitCnt <= 0; byteCnt <= 0; ackPhase <= 1'b0;
    end else if (sclPrev && sclLine && !sdaPrev && sdaLine) begin
      stopCnt <= stopCnt + 1;
      stopAt[transCnt[5:0]] <= cyc;
      inFrame <= 1'b0;
      transCnt <= transCnt + 1;
    end else if (inFrame && !sclPrev && sclLine && bitCnt < 8 && !ackPhase) begin
      shiftIn <= {shiftIn[6:0], sdaLine};
      bitCnt <= bitCnt + 1;
    end else if (inFrame && sclPrev && !sclLine) begin
      lastHigh <= highLen;
      if (ackPhase) begin
        ackDrive <= 1'b0; ackPhase <= 1'b0; bitCnt <= 0; byteCnt <= byteCnt + 1;
      end else if (bitCnt == 8) begin
        if (byteCnt < 3) byteLog[transCnt[5:0]][byteCnt] <= shiftIn;
        ackPhase <= 1'b1;
        ackDrive <= !(transCnt == nackTrans && byteCnt == nackByte);
      end
    end
  end

  function automatic int expReg(input int k);
    case (k)
      0: return 15; 1: return 6; 2: return 2; 3: return 3; 4: return 4; 5: return 5;
      6: return 7; 7: return 8; 8: return 9; 9: return 6; default: return 4;
    endcase
  endfunction

  function automatic int expVal(input int k);
    case (k)
      1: return 'h070; 2: return 'h179; 3: return 'h179; 6: return 'h001;
      8: return 'h001; 9: return 'h020; 10: return 'h016; default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitResult();
    for (int i = 0; i < 20000 && !(done || error); i++) @(negedge clk);
  endtask

  task automatic verifyLog(input int base);
    for (int k = 0; k < 11; k++) begin
      int v = expVal(k);
      int gap;
      bit pauseHere;
      check("R1", "address byte", byteLog[base+k][0], 'h34);
      check("R2", "register byte", byteLog[base+k][1], (expReg(k) << 1) | (v >> 8));
      check("R3", "value byte", byteLog[base+k][2], v & 'hFF);
      if (k < 10) begin
        gap = startAt[base+k+1] - stopAt[base+k];
        pauseHere = (k == 0 || k == 7 || k == 8 || k == 9);
        check("R4", "pause placement", int'(gap >= W), int'(pauseHere));
      end
    end
  endtask

  // Power-up after reset, with a start pulse during the run
  task automatic t_power_up();
    doReset();
    check("R10", "done after reset", done, 0);
    check("R10", "error after reset", error, 0);
    check("R11", "scl released after reset", sclOe, 0);
    check("R11", "sda released after reset", sdaOe, 0);
    while (transCnt < 3) @(negedge clk);
    pulseStart();
    waitResult();
    check("R8", "done after full run", done, 1);
    check("R7", "no error on full run", error, 0);
    check("R9", "write count with busy start", transCnt, 11);
    check("R6", "start conditions", startCnt, 11);
    check("R6", "stop conditions", stopCnt, 11);
    check("R5", "scl high phase length", lastHigh, 2 * Q);
    verifyLog(0);
  endtask

  task automatic t_done_sticky();
    int base = transCnt;
    repeat (300) @(negedge clk);
    check("R8", "done held while idle", done, 1);
    check("R8", "no traffic while idle", transCnt, base);
    check("R11", "lines released when done", int'({sclOe, sdaOe}), 0);
  endtask

  task automatic t_restart();
    int base = transCnt;
    pulseStart();
    check("R10", "done cleared by start", done, 0);
    waitResult();
    check("R10", "done after rerun", done, 1);
    check("R10", "rerun write count", transCnt, base + 11);
    verifyLog(base);
  endtask

  task automatic t_nack_data();
    int base = transCnt;
    nackTrans = base + 3; nackByte = 1;
    pulseStart();
    waitResult();
    check("R7", "error on data nack", error, 1);
    check("R7", "done low on nack", done, 0);
    check("R7", "writes up to nack", transCnt, base + 4);
    check("R6", "stop sent after nack", stopCnt, startCnt);
    repeat (500) @(negedge clk);
    check("R7", "no writes after abort", transCnt, base + 4);
    check("R7", "error held", error, 1);
    check("R11", "lines released on error", int'({sclOe, sdaOe}), 0);
    nackTrans = -1;
    base = transCnt;
    doReset();
    check("R10", "error cleared by reset", error, 0);
    waitResult();
    check("R10", "run after reset", done, 1);
    check("R10", "writes after reset", transCnt, base + 11);
    verifyLog(base);
  endtask

  task automatic t_nack_addr();
    int base = transCnt;
    nackTrans = base; nackByte = 0;
    pulseStart();
    waitResult();
    nackTrans = -1;
    check("R7", "error on address nack", error, 1);
    check("R7", "single write on address nack", transCnt, base + 1);
    check("R1", "address byte before nack", byteLog[base][0], 'h34);
    check("R6", "stop after address nack", stopCnt, startCnt);
  endtask

  initial begin
    t_power_up();
    t_done_sticky();
    t_restart();
    t_nack_data();
    t_nack_addr();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule